// File: doc/BRIEF.md
# Dual-Source Acquisition Trigger with Scaler Hold

The block forms the acquisition trigger from two independent sources. The physics source is a coincidence of scintillator hit inputs, optionally gated by the RF timing input. The mask input selects which terms take part. The scaler source is the load-next-event pulse that the scaler raises each time it reaches its programmed prescale and latches its counts. The readout needs every one of those latched snapshots. A scaler request that finds the acquisition busy is therefore held pending until busy falls, and it is never discarded.

All inputs pass through one register stage, and edges are found by comparing against a second, delayed copy. A physics coincidence fires once, on the rising edge of the combined condition. It is dropped if busy is high or if a scaler request is issued in the same cycle. Each trigger is a one-cycle pulse with a 2-bit tag naming its source. A second load-next-event edge that arrives while an earlier request is still waiting sets a sticky overrun flag.

Top module: `trig_unit`

## Requirements
- R1: After reset, trig_o is 0, src_o is 2'b00 and overrun_o is 0.
- R2: The coincidence condition is true when every scintillator bit enabled in coinc_mask_i[N_SCINT-1:0] is high, and also rf_i is high if coinc_mask_i[N_SCINT] is set. If at least one mask bit is set and busy_i is low, a rising edge of the condition at the inputs gives trig_o high with src_o = 2'b01 on the second clock edge after the change.
- R3: Scintillator bits whose mask bit is 0 have no effect on the condition. When the whole mask is zero, no physics trigger is ever issued.
- R4: A coincidence condition that stays true issues only one physics trigger.
- R5: While busy_i is high at a decision edge, no trigger is issued, and a physics coincidence edge in that cycle is lost.
- R6: A rising edge of lne_i makes a scaler request pending. The pending request is issued with src_o = 2'b10 on the first clock edge at which busy_i is low. With busy_i low throughout, trig_o rises on the third edge after lne_i rises.
- R7: A pending scaler request is held for any number of busy cycles and is then issued exactly once.
- R8: When a pending scaler request and a physics coincidence edge meet at the same non-busy edge, only the scaler trigger is issued (src_o = 2'b10), and the physics trigger is dropped.
- R9: A rising edge of lne_i that arrives while a request is pending and not being issued sets overrun_o. overrun_o then stays 1 until reset.
- R10: trig_o is high for one cycle per trigger, and src_o is 2'b00 whenever trig_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Acquisition busy |
| scint_i | input | N_SCINT | Scintillator hit inputs |
| rf_i | input | 1 | RF timing input |
| lne_i | input | 1 | Scaler load-next-event pulse |
| coinc_mask_i | input | N_SCINT+1 | Scintillator enables; top bit requires RF |
| trig_o | output | 1 | One-cycle trigger pulse |
| src_o | output | 2 | Trigger source: 01 physics, 10 scaler, 00 none |
| overrun_o | output | 1 | Sticky scaler request overrun |

## Verification
The hardest case to reach is the collision between a held scaler request and a physics edge at the same edge where busy falls. The bench holds busy high while the request is pending and raises the coincidence one cycle before busy drops. Both sources then become eligible at the same decision edge. A full sweep over every mask and scintillator pattern checks the coincidence function, counting the physics triggers in each case against a count worked out from the mask.

// File: rtl/trig_unit_pkg.sv
package trig_unit_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'b00,
    SRC_PHYS   = 2'b01,
    SRC_SCALER = 2'b10
  } trig_src_e;
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] q, q_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q      <= '0;
      q_prev <= '0;
    end else begin
      q      <= d_i;
      q_prev <= q;
    end
  end

  assign lvl_o  = q;
  assign rise_o = q & ~q_prev;
endmodule

// File: rtl/trig_coinc.sv
module trig_coinc #(
  parameter int N_SCINT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SCINT-1:0] hit_i,
  input  logic               rf_i,
  input  logic [N_SCINT:0]   mask_i,
  output logic               evt_o
);
  logic [N_SCINT:0] term;
  logic             any_en, lvl, lvl_prev;

  assign term   = {rf_i, hit_i} | ~mask_i;
  assign any_en = |mask_i;
  assign lvl    = any_en & (&term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_prev <= 1'b0;
    else         lvl_prev <= lvl;
  end

  assign evt_o = lvl & ~lvl_prev;

  assert_single_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/trig_hold.sv
module trig_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic grant_i,
  output logic pend_o,
  output logic overrun_o
);
  logic pend_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      pend_q <= req_i | (pend_q & ~grant_i);
      if (req_i && pend_q && !grant_i) ovr_q <= 1'b1;
    end
  end

  assign pend_o    = pend_q;
  assign overrun_o = ovr_q;

  assert_pend_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !grant_i |=> pend_q);
  assert_overrun_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q);
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_unit_pkg::*;
#(
  parameter int N_SCINT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               busy_i,
  input  logic [N_SCINT-1:0] scint_i,
  input  logic               rf_i,
  input  logic               lne_i,
  input  logic [N_SCINT:0]   coinc_mask_i,
  output logic               trig_o,
  output logic [1:0]         src_o,
  output logic               overrun_o
);
  localparam int W_IN = N_SCINT + 2;

  logic [W_IN-1:0] in_lvl, in_rise;
  logic            phys_evt, pend, grant_scl, grant_phys;
  logic            trig_q;
  trig_src_e       src_q;

  trig_sync_edge #(.W(W_IN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({lne_i, rf_i, scint_i}),
    .lvl_o  (in_lvl),
    .rise_o (in_rise)
  );

  trig_coinc #(.N_SCINT(N_SCINT)) u_coinc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (in_lvl[N_SCINT-1:0]),
    .rf_i   (in_lvl[N_SCINT]),
    .mask_i (coinc_mask_i),
    .evt_o  (phys_evt)
  );

  trig_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (in_rise[N_SCINT+1]),
    .grant_i   (grant_scl),
    .pend_o    (pend),
    .overrun_o (overrun_o)
  );

  // scaler request has priority over a physics edge
  assign grant_scl  = pend & ~busy_i;
  assign grant_phys = phys_evt & ~busy_i & ~pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      src_q  <= SRC_NONE;
    end else begin
      trig_q <= grant_scl | grant_phys;
      if (grant_scl)       src_q <= SRC_SCALER;
      else if (grant_phys) src_q <= SRC_PHYS;
      else                 src_q <= SRC_NONE;
    end
  end

  assign trig_o = trig_q;
  assign src_o  = src_q;

  assert_busy_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !trig_o);
  assert_scaler_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend && !busy_i |=> trig_o && src_o == SRC_SCALER);
  assert_tag_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (src_o == SRC_PHYS || src_o == SRC_SCALER));
endmodule

// File: tb/tb_trig_unit.sv
module tb_trig_unit;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         busy = 1'b0;
  logic [N-1:0] scint = '0;
  logic         rf = 1'b0;
  logic         lne = 1'b0;
  logic [N:0]   mask = '0;
  logic         trig;
  logic [1:0]   src;
  logic         ovr;

  int n_chk = 0, n_fail = 0;
  int cnt_phys = 0, cnt_scl = 0, cnt_bad = 0;
  bit mon_en = 1'b0;

  always #2 clk = ~clk;

  trig_unit #(.N_SCINT(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .scint_i(scint), .rf_i(rf),
    .lne_i(lne), .coinc_mask_i(mask), .trig_o(trig), .src_o(src), .overrun_o(ovr)
  );

  always @(negedge clk) if (mon_en) begin
    if (trig && src == 2'b01) cnt_phys++;
    else if (trig && src == 2'b10) cnt_scl++;
    else if (trig || src != 2'b00) cnt_bad++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    cnt_phys = 0; cnt_scl = 0; cnt_bad = 0;
  endtask

  task automatic lne_pulse();
    lne = 1'b1; cyc(1); lne = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R1 trig", trig, 0); chk("R1 src", src, 0); chk("R1 ovr", ovr, 0);
    rst_n = 1'b1;
    cyc(2);
    mon_en = 1'b1;

    // R2 latency, R10 one-cycle pulse, R4 single trigger on held level
    mask = 4'b0001; cyc(3); clr();
    scint = 3'b001; cyc(1);
    chk("R2 no trig after edge 1", trig, 0);
    cyc(1);
    chk("R2 trig edge 2", trig, 1); chk("R2 src", src, 1);
    cyc(1);
    chk("R10 pulse ended", trig, 0); chk("R10 src idle", src, 0);
    cyc(10);
    chk("R4 one trigger on held level", cnt_phys, 1);
    scint = '0; cyc(3);

    // R2/R3 sweep over every mask and scintillator pattern
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 8; p++) begin
        int exp;
        mask = m[3:0]; scint = '0; rf = 1'b0; cyc(4); clr();
        scint = p[2:0]; cyc(4);
        rf = 1'b1; cyc(4);
        exp = (m != 0 && ((p & m & 7) == (m & 7))) ? 1 : 0;
        chk($sformatf("R3 mask=%0h pat=%0h phys", m, p), cnt_phys, exp);
        rf = 1'b0; scint = '0;
      end
    end
    chk("R10 no bad tag", cnt_bad, 0);

    // R5 busy drops physics edge
    mask = 4'b0011; cyc(4); clr();
    busy = 1'b1; scint = 3'b011; cyc(5);
    busy = 1'b0; cyc(5);
    chk("R5 physics dropped while busy", cnt_phys, 0);
    scint = '0; cyc(3);

    // R6 scaler latency with busy low
    clr(); lne = 1'b1; cyc(1);
    chk("R6 no trig edge 1", trig, 0);
    lne = 1'b0; cyc(1);
    chk("R6 no trig edge 2", trig, 0);
    cyc(1);
    chk("R6 trig edge 3", trig, 1); chk("R6 src", src, 2);
    cyc(3);
    chk("R6 single scaler trig", cnt_scl, 1);

    // R7 held across a long busy, then issued once
    clr(); busy = 1'b1; lne_pulse(); cyc(40);
    chk("R7 held while busy", cnt_scl, 0);
    busy = 1'b0; cyc(1);
    chk("R7 issued when busy falls", trig, 1); chk("R7 src", src, 2);
    cyc(5);
    chk("R7 exactly once", cnt_scl, 1);
    chk("R9 no overrun on single request", ovr, 0);

    // R8 collision: pending scaler and physics edge at the same edge
    mask = 4'b0001; scint = '0; cyc(4); clr();
    busy = 1'b1; lne_pulse(); cyc(4);
    scint = 3'b001; cyc(1);
    busy = 1'b0; cyc(1);
    chk("R8 scaler issued", trig, 1); chk("R8 scaler src", src, 2);
    cyc(5);
    chk("R8 physics dropped", cnt_phys, 0);
    chk("R8 one scaler", cnt_scl, 1);
    scint = '0; cyc(3);

    // R9 overrun
    clr(); busy = 1'b1; lne_pulse(); cyc(3);
    chk("R9 no overrun yet", ovr, 0);
    lne_pulse(); cyc(3);
    chk("R9 overrun set", ovr, 1);
    busy = 1'b0; cyc(5);
    chk("R9 overrun sticky", ovr, 1);
    chk("R9 pending still issued", cnt_scl, 1);
    rst_n = 1'b0; cyc(1);
    chk("R1 overrun cleared by reset", ovr, 0);
    rst_n = 1'b1; cyc(2);

    chk("R10 no bad tag overall", cnt_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule